// File: doc/BRIEF.md
# Three-Level Port Interrupt Aggregator

The aggregator funnels interrupt conditions from a set of identical transceiver ports into one active-low interrupt request. Each port raises single-cycle event pulses in four status groups (transmit, receive, line, test). Every pulse is captured in a per-port latched status register. The host clears a latched bit by writing a 1 to its position. A mask register beside each latched register decides whether a latched bit may propagate upward. It never stops the bit from being captured, so the host can poll masked conditions through the same latched registers.

Above the latched registers sit two purely combinational summary levels. A per-port information register reports whether the transmit group or the receive group holds any unmasked latched bit. Three global information registers give one bit per port: one for framer activity (transmit or receive), one for the line group and one for the test group. A per-port global enable mask then gates which ports may pull the interrupt pin low.

The host uses a single-cycle synchronous write port and a combinational read port. The address is `{space, port, offset}`. The space bit is the most significant bit: 0 selects a port's registers and 1 selects the global registers. The port index sits next, followed by a 4-bit offset in the low bits.

Top module: `irqAggregator`

## Requirements
- R1: An event pulse on a status bit sets that latched bit at the next clock edge, whatever its mask bit holds. The bit then stays set until the host clears it.
- R2: The latched registers sit at port offsets 0 (transmit), 1 (receive), 2 (line) and 3 (test). Writing to one of them clears exactly the bit positions written as 1. Bit positions written as 0 keep their value.
- R3: If an event and a clearing write hit the same bit in the same cycle, the bit stays set. Other bits cleared by that write still clear.
- R4: After reset, all latched bits read 0. Every mask bit reads 1, both in the per-port masks at offsets 4 to 7 (same group order as the latched registers) and in the global enable mask. Mask registers read back the last value written.
- R5: The per-port information register is read-only at offset 8. Bit 0 is set while any transmit latched bit is unmasked. Bit 1 is set while any receive latched bit is unmasked. It follows the latched and mask registers in the same cycle, with no extra delay.
- R6: With the space bit set, offset 0 reads the framer summary: bit p is set when port p's information register is nonzero. Offset 1 reads the line summary and offset 2 reads the test summary: bit p is set when port p holds an unmasked latched bit in that group.
- R7: The global enable mask sits at global offset 3 and has one bit per port; 0 means enabled. The interrupt output is 0 exactly when some enabled port has a bit set in any of the three global summaries. Otherwise it is 1.
- R8: Latched registers always return the raw latched bits, including bits that are masked.
- R9: Reads of unmapped offsets return zero: port offsets 9 to 15 and global offsets 4 to 15. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Host write strobe |
| addr | input | 1+PORT_W+4 | `{space, port, offset}` |
| wrData | input | DATA_W | Host write data |
| rdData | output | DATA_W | Combinational read data for `addr` |
| evTx | input | NUM_PORTS*STAT_W | Transmit event pulses, port p at bits p*STAT_W |
| evRx | input | NUM_PORTS*STAT_W | Receive event pulses |
| evLine | input | NUM_PORTS*STAT_W | Line event pulses |
| evTest | input | NUM_PORTS*STAT_W | Test event pulses |
| intN | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with four ports, four status bits per group and an 8-bit data bus. This keeps the space small enough to sweep every single status bit of every group and port. For each bit the sweep covers latching under mask, unmasking, global enabling and both forms of write-one-to-clear. The same small size lets the bench read back every register and summary after each step and compare it against a model built from the requirements. It also lets the bench walk every unmapped offset and try the event-versus-clear collision on chosen bits.

// File: rtl/irqAggPkg.sv
package irqAggPkg;
  localparam int NUM_GROUPS = 4;   // tx, rx, line, test
  localparam int OFF_MASK0 = 4;
  localparam int OFF_INFO = 8;
  localparam int GOFF_FRM = 0;
  localparam int GOFF_LINE = 1;
  localparam int GOFF_TEST = 2;
  localparam int GOFF_GMASK = 3;

  typedef enum logic [2:0] {
    RD_NONE, RD_LATCH, RD_MASK, RD_INFO, RD_GFRM, RD_GLINE, RD_GTEST, RD_GMASK
  } rdSel_e;

  typedef struct packed {
    logic [NUM_GROUPS-1:0] latchClr;
    logic [NUM_GROUPS-1:0] maskWr;
    logic                  gMaskWr;
    rdSel_e                rdSel;
    logic [1:0]            rdGroup;
  } hostStrobe_t;
endpackage

// File: rtl/irqAggCtrl.sv
module irqAggCtrl
  import irqAggPkg::*;
#(
  parameter int PORT_W = 3,
  parameter int ADDR_W = 1 + PORT_W + 4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output hostStrobe_t       strobe,
  output logic [PORT_W-1:0] portIdx
);
  logic [3:0] offset;
  logic       isGlobal;

  assign offset   = addr[3:0];
  assign portIdx  = addr[PORT_W+3:4];
  assign isGlobal = addr[ADDR_W-1];

  always_comb begin
    strobe = '0;
    strobe.rdGroup = offset[1:0];
    if (isGlobal) begin
      unique case (int'(offset))
        GOFF_FRM:   strobe.rdSel = RD_GFRM;
        GOFF_LINE:  strobe.rdSel = RD_GLINE;
        GOFF_TEST:  strobe.rdSel = RD_GTEST;
        GOFF_GMASK: begin
          strobe.rdSel   = RD_GMASK;
          strobe.gMaskWr = wrEn;
        end
        default:    strobe.rdSel = RD_NONE; // R9
      endcase
    end else if (offset < 4'(OFF_MASK0)) begin
      strobe.rdSel = RD_LATCH;
      strobe.latchClr[offset[1:0]] = wrEn;      // R2
    end else if (offset < 4'(OFF_INFO)) begin
      strobe.rdSel = RD_MASK;
      strobe.maskWr[offset[1:0]] = wrEn;        // R4
    end else if (offset == 4'(OFF_INFO)) begin
      strobe.rdSel = RD_INFO;                   // R5
    end else begin
      strobe.rdSel = RD_NONE;                   // R9
    end
  end
endmodule

// File: rtl/irqAggStatusReg.sv
module irqAggStatusReg #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] ev,
  input  logic              clrEn,
  input  logic [STAT_W-1:0] clrData,
  input  logic              maskWrEn,
  input  logic [STAT_W-1:0] maskData,
  output logic [STAT_W-1:0] latchQ,
  output logic [STAT_W-1:0] maskQ,
  output logic              pending
);
  logic [STAT_W-1:0] clrBits;

  assign clrBits = clrEn ? clrData : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      latchQ <= '0;
      maskQ  <= '1;
    end else begin
      // R1/R3: an event wins over a same-cycle clear
      latchQ <= (latchQ & ~clrBits) | ev;
      if (maskWrEn) maskQ <= maskData;
    end
  end

  assign pending = |(latchQ & ~maskQ);
endmodule

// File: rtl/irqAggDatapath.sv
module irqAggDatapath
  import irqAggPkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int STAT_W = 8,
  parameter int DATA_W = 8,
  parameter int PORT_W = 3,
  localparam int GRP_BITS = NUM_PORTS * STAT_W,
  localparam int ALL_BITS = NUM_GROUPS * GRP_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  hostStrobe_t         strobe,
  input  logic [PORT_W-1:0]   portIdx,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ALL_BITS-1:0] evAll,
  output logic [DATA_W-1:0]   rdData,
  output logic                intN,
  output logic [ALL_BITS-1:0] latchObs,
  output logic [ALL_BITS-1:0] maskObs,
  output logic [NUM_PORTS-1:0] gMaskObs
);
  logic [STAT_W-1:0] latchArr [NUM_GROUPS][NUM_PORTS];
  logic [STAT_W-1:0] maskArr  [NUM_GROUPS][NUM_PORTS];
  logic [NUM_GROUPS*NUM_PORTS-1:0] pend;
  logic [NUM_PORTS-1:0] gFrm, gLine, gTest, gMask;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam int BASE = (g * NUM_PORTS + p) * STAT_W;
      logic portHit;
      assign portHit = (portIdx == PORT_W'(p));

      irqAggStatusReg #(.STAT_W(STAT_W)) stat_i (
        .clk      (clk),
        .rst      (rst),
        .ev       (evAll[BASE +: STAT_W]),
        .clrEn    (strobe.latchClr[g] && portHit),
        .clrData  (wrData[STAT_W-1:0]),
        .maskWrEn (strobe.maskWr[g] && portHit),
        .maskData (wrData[STAT_W-1:0]),
        .latchQ   (latchArr[g][p]),
        .maskQ    (maskArr[g][p]),
        .pending  (pend[g*NUM_PORTS+p])
      );
      assign latchObs[BASE +: STAT_W] = latchArr[g][p];
      assign maskObs[BASE +: STAT_W]  = maskArr[g][p];
    end
  end

  // R6: per-port bits of the global summaries
  assign gFrm  = pend[0 +: NUM_PORTS] | pend[NUM_PORTS +: NUM_PORTS];
  assign gLine = pend[2*NUM_PORTS +: NUM_PORTS];
  assign gTest = pend[3*NUM_PORTS +: NUM_PORTS];

  always_ff @(posedge clk) begin
    if (rst) gMask <= '1;
    else if (strobe.gMaskWr) gMask <= wrData[NUM_PORTS-1:0];
  end
  assign gMaskObs = gMask;

  // R7
  assign intN = ~|((gFrm | gLine | gTest) & ~gMask);

  always_comb begin
    rdData = '0;
    unique case (strobe.rdSel)
      RD_GFRM:  rdData[NUM_PORTS-1:0] = gFrm;
      RD_GLINE: rdData[NUM_PORTS-1:0] = gLine;
      RD_GTEST: rdData[NUM_PORTS-1:0] = gTest;
      RD_GMASK: rdData[NUM_PORTS-1:0] = gMask;
      default:  rdData = '0;
    endcase
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (portIdx == PORT_W'(p)) begin
        unique case (strobe.rdSel)
          RD_LATCH: rdData[STAT_W-1:0] = latchArr[strobe.rdGroup][p]; // R8
          RD_MASK:  rdData[STAT_W-1:0] = maskArr[strobe.rdGroup][p];
          RD_INFO:  rdData[1:0] = {pend[NUM_PORTS+p], pend[p]};       // R5
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqAggregator.sv
module irqAggregator
  import irqAggPkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int STAT_W = 8,
  parameter int DATA_W = 8,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int ADDR_W = 1 + PORT_W + 4,
  localparam int GRP_BITS = NUM_PORTS * STAT_W,
  localparam int ALL_BITS = NUM_GROUPS * GRP_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [GRP_BITS-1:0] evTx,
  input  logic [GRP_BITS-1:0] evRx,
  input  logic [GRP_BITS-1:0] evLine,
  input  logic [GRP_BITS-1:0] evTest,
  output logic                intN
);
  hostStrobe_t          strobe;
  logic [PORT_W-1:0]    portIdx;
  logic [ALL_BITS-1:0]  evAll;
  logic [ALL_BITS-1:0]  latchObs;
  logic [ALL_BITS-1:0]  maskObs;
  logic [NUM_PORTS-1:0] gMaskObs;

  assign evAll = {evTest, evLine, evRx, evTx};

  irqAggCtrl #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) ctrl_i (
    .wrEn    (wrEn),
    .addr    (addr),
    .strobe  (strobe),
    .portIdx (portIdx)
  );

  irqAggDatapath #(
    .NUM_PORTS (NUM_PORTS),
    .STAT_W    (STAT_W),
    .DATA_W    (DATA_W),
    .PORT_W    (PORT_W)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .portIdx  (portIdx),
    .wrData   (wrData),
    .evAll    (evAll),
    .rdData   (rdData),
    .intN     (intN),
    .latchObs (latchObs),
    .maskObs  (maskObs),
    .gMaskObs (gMaskObs)
  );
endmodule

// File: rtl/irqAggChecker.sv
module irqAggChecker #(
  parameter int NUM_PORTS = 8,
  parameter int STAT_W = 8,
  localparam int ALL_BITS = 4 * NUM_PORTS * STAT_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wrEn,
  input logic [ALL_BITS-1:0]  evAll,
  input logic [ALL_BITS-1:0]  latchObs,
  input logic [ALL_BITS-1:0]  maskObs,
  input logic [NUM_PORTS-1:0] gMaskObs,
  input logic                 intN
);
  // R1
  ev_sets_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (|evAll) |=> ((latchObs & $past(evAll)) == $past(evAll)));

  // R1
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((latchObs & ~$past(latchObs) & ~$past(evAll)) == '0));

  // R2
  clear_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    ((~latchObs & $past(latchObs)) != '0) |-> $past(wrEn));

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wrEn) |-> ((maskObs == $past(maskObs)) && (gMaskObs == $past(gMaskObs))));

  // R7
  int_source_chk: assert property (@(posedge clk) disable iff (rst)
    !intN |-> ((latchObs & ~maskObs) != '0));

  // R7
  int_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ((latchObs & ~maskObs) == '0) |-> intN);
endmodule

bind irqAggregator irqAggChecker #(.NUM_PORTS(NUM_PORTS), .STAT_W(STAT_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .wrEn     (wrEn),
  .evAll    (evAll),
  .latchObs (latchObs),
  .maskObs  (maskObs),
  .gMaskObs (gMaskObs),
  .intN     (intN)
);

// File: tb/irqAggregator_tb_top.sv
module irqAggregator_tb_top;
  localparam int NP = 4;
  localparam int SW = 4;
  localparam int DW = 8;
  localparam int PW = 2;
  localparam int AW = 1 + PW + 4;
  localparam int FULL = (1 << SW) - 1;
  localparam int PFULL = (1 << NP) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic [NP*SW-1:0] evBus [4];
  logic intN;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int mLatch [4][NP];
  int mMask  [4][NP];
  int mGMask;

  always #10 clk = ~clk;

  irqAggregator #(.NUM_PORTS(NP), .STAT_W(SW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .evTx(evBus[0]), .evRx(evBus[1]), .evLine(evBus[2]),
    .evTest(evBus[3]), .intN(intN)
  );

  function automatic int mkAddr(int glob, int p, int off);
    return (glob << (PW + 4)) | (p << 4) | off;
  endfunction

  function automatic int expInfo(int p);
    int v = 0;
    if ((mLatch[0][p] & ~mMask[0][p]) != 0) v |= 1;
    if ((mLatch[1][p] & ~mMask[1][p]) != 0) v |= 2;
    return v;
  endfunction

  function automatic int expGlobal(int k);
    int v = 0;
    for (int p = 0; p < NP; p++) begin
      if (k == 0 && expInfo(p) != 0) v |= (1 << p);
      if (k > 0 && (mLatch[k+1][p] & ~mMask[k+1][p]) != 0) v |= (1 << p);
    end
    return v;
  endfunction

  function automatic int expIntN();
    int any = expGlobal(0) | expGlobal(1) | expGlobal(2);
    return ((any & ~mGMask & PFULL) != 0) ? 0 : 1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostRead(int a, output int d);
    addr = AW'(a);
    #2;
    d = int'(rdData);
  endtask

  task automatic hostWrite(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(a); wrData = DW'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulse(int g, int p, int bits);
    @(negedge clk);
    evBus[g][p*SW +: SW] = SW'(bits);
    @(negedge clk);
    evBus[g] = '0;
    mLatch[g][p] |= bits;
  endtask

  task automatic verifyPort(int p);
    int d;
    for (int g = 0; g < 4; g++) begin
      hostRead(mkAddr(0, p, g), d);     check("R1/R2/R8 latch", d, mLatch[g][p]);
      hostRead(mkAddr(0, p, 4 + g), d); check("R4 mask", d, mMask[g][p]);
    end
    hostRead(mkAddr(0, p, 8), d); check("R5 info", d, expInfo(p));
    for (int k = 0; k < 3; k++) begin
      hostRead(mkAddr(1, 0, k), d); check("R6 global", d, expGlobal(k));
    end
    hostRead(mkAddr(1, 0, 3), d); check("R7 gmask", d, mGMask);
    check("R7 intN", int'(intN), expIntN());
  endtask

  task automatic verifyAll();
    for (int p = 0; p < NP; p++) verifyPort(p);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d;
    for (int g = 0; g < 4; g++) evBus[g] = '0;
    for (int g = 0; g < 4; g++)
      for (int p = 0; p < NP; p++) begin mLatch[g][p] = 0; mMask[g][p] = FULL; end
    mGMask = PFULL;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R4 reset state
    verifyAll();

    // Single-bit sweep over every group, port and bit
    for (int g = 0; g < 4; g++)
      for (int p = 0; p < NP; p++)
        for (int b = 0; b < SW; b++) begin
          pulse(g, p, 1 << b);                 // R1 latched while masked
          verifyPort(p);
          hostWrite(mkAddr(0, p, 4 + g), FULL & ~(1 << b));
          mMask[g][p] = FULL & ~(1 << b);      // R5/R6 unmasked
          verifyPort(p);
          hostWrite(mkAddr(1, 0, 3), PFULL & ~(1 << p));
          mGMask = PFULL & ~(1 << p);          // R7 enabled
          verifyPort(p);
          hostWrite(mkAddr(0, p, g), FULL & ~(1 << b)); // R2 zeros keep bit
          verifyPort(p);
          hostWrite(mkAddr(0, p, g), 1 << b);  // R2 clear
          mLatch[g][p] &= ~(1 << b);
          verifyPort(p);
          hostWrite(mkAddr(0, p, 4 + g), FULL); mMask[g][p] = FULL;
          hostWrite(mkAddr(1, 0, 3), PFULL);    mGMask = PFULL;
        end

    // R8: raw reads under masking with a mixed pattern
    for (int g = 0; g < 4; g++)
      for (int p = 0; p < NP; p++) begin
        pulse(g, p, (p * 5 + g * 3 + 1) & FULL);
        hostWrite(mkAddr(0, p, 4 + g), (p + g * 2) & FULL);
        mMask[g][p] = (p + g * 2) & FULL;
      end
    hostWrite(mkAddr(1, 0, 3), 4'b0101); mGMask = 4'b0101;
    verifyAll();

    // R9: unmapped writes change nothing, unmapped reads return zero
    for (int off = 9; off < 16; off++) hostWrite(mkAddr(0, 1, off), 8'hFF);
    for (int off = 4; off < 16; off++) hostWrite(mkAddr(1, 0, off), 8'hFF);
    verifyAll();
    for (int p = 0; p < NP; p++)
      for (int off = 9; off < 16; off++) begin
        hostRead(mkAddr(0, p, off), d); check("R9 port unmapped", d, 0);
      end
    for (int off = 4; off < 16; off++) begin
      hostRead(mkAddr(1, 0, off), d); check("R9 global unmapped", d, 0);
    end

    // clear everything
    for (int g = 0; g < 4; g++)
      for (int p = 0; p < NP; p++) begin
        hostWrite(mkAddr(0, p, g), FULL); mLatch[g][p] = 0;
      end
    verifyAll();

    // R3: event and clear of the same bit in one cycle
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(mkAddr(0, 2, 1)); wrData = DW'(FULL);
    evBus[1][2*SW +: SW] = SW'(4'b0100);
    @(negedge clk);
    wrEn = 1'b0; evBus[1] = '0;
    mLatch[1][2] = 4'b0100;
    verifyPort(2);
    // R3: another bit cleared in the same cycle still clears
    pulse(1, 2, 4'b0001);
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(mkAddr(0, 2, 1)); wrData = DW'(4'b0101);
    evBus[1][2*SW +: SW] = SW'(4'b1000);
    @(negedge clk);
    wrEn = 1'b0; evBus[1] = '0;
    mLatch[1][2] = 4'b1000;
    verifyPort(2);
    hostRead(mkAddr(0, 2, 1), d); check("R3 collision", d, 4'b1000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule